// File: doc/BRIEF.md
# Programmable Cyclic Pattern Generator

This block replays a sequence of memory-test data words that software has placed in a small on-chip buffer. A processor fills the buffer through a write-only port and sets the replay length through a separate control/status register port. While generation is enabled, the block sends buffer entries in index order over a valid/ready streaming source. After the last programmed entry it goes straight back to entry zero, so the output repeats with no gap.

The block does not generate walking-bit, frequency or pseudo-random sequences itself. Software preloads the elements of whichever pattern it wants. The buffer holds 256 entries, so the longest pseudo-random sequence fits. A two-entry setting gives the alternating high- and low-frequency patterns. A walking-ones or walking-zeros test uses as many entries as the word has bits.

Back-pressure rules: the consumer takes a word on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` stay unchanged. The replay position moves only when a word is accepted.

Top module: `pat_replay_gen`

## Requirements
- R1: After reset, `out_valid` is low and both registers read as zero.
- R2: A write on the pattern port, made while the block is idle, stores `pat_wdata` at entry `pat_addr`. The stored word is later streamed out unchanged at that position. The port has no read path.
- R3: After the word at index length−1 is accepted, the next word offered is entry 0, in the following cycle and with no gap.
- R4: The replay index moves to the next entry only on a cycle where `out_valid` and `out_ready` are both high.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R6: Control register (`csr_sel`=0) layout: bit 0 is the enable, and bits 8:1 hold length−1. It reads back as written. Status register (`csr_sel`=1) layout: bit 0 is busy, which equals `out_valid`, and the other bits read zero.
- R7: Clearing the enable stops the stream only after the pending word is accepted. The word stays offered until then, and `out_valid` and busy fall in the cycle after that acceptance.
- R8: Setting the enable from the idle state makes `out_valid` rise in the next cycle, offering entry 0.
- R9: Pattern-port writes are ignored while the enable is set or a word is still pending.
- R10: Lengths of 1, 2 and 256 replay correctly, including the full 256-entry buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_we | input | 1 | Pattern buffer write strobe |
| pat_addr | input | 8 | Pattern buffer entry index |
| pat_wdata | input | 32 | Pattern word to store |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | Register select: 0 control, 1 status |
| csr_wdata | input | 9 | Register write data |
| csr_rdata | output | 9 | Register read data for the selected register (combinational) |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream consumer ready |
| out_data | output | 32 | Stream word |

## Verification
Two events can fall in the same cycle: stopping, when the enable is cleared, and back-pressure, when `out_ready` is held low. The bench clears the enable while the consumer stalls. It then checks that the pending word stays offered with unchanged data, and that the stream ends exactly one cycle after the consumer accepts it. A buffer write can also land in the same cycle as streaming. The bench writes a different word to entry 0 right after enabling, then checks that entry 0 still streams the original word each time the sequence wraps.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int EN_BIT  = 0;
  localparam int LEN_LSB = 1;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } csr_sel_e;
endpackage

// File: rtl/pat_buffer.sv
module pat_buffer #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/pat_csr.sv
module pat_csr
  import prg_pkg::*;
#(
  parameter int AW    = 8,
  localparam int CW   = LEN_LSB + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [CW-1:0] wdata,
  input  logic          busy,
  output logic [CW-1:0] rdata,
  output logic          enable,
  output logic [AW-1:0] len_m1,
  output logic          start
);
  logic wr_ctrl;

  assign wr_ctrl = we && (csr_sel_e'(sel) == SEL_CTRL);
  assign start   = wr_ctrl && wdata[EN_BIT] && !enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
      len_m1 <= '0;
    end else if (wr_ctrl) begin
      enable <= wdata[EN_BIT];
      len_m1 <= wdata[LEN_LSB +: AW];
    end
  end

  always_comb begin
    rdata = '0;
    if (csr_sel_e'(sel) == SEL_CTRL) begin
      rdata[EN_BIT]        = enable;
      rdata[LEN_LSB +: AW] = len_m1;
    end else begin
      rdata[0] = busy;
    end
  end
endmodule

// File: rtl/pat_seq.sv
module pat_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          enable,
  input  logic [AW-1:0] len_m1,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] idx
);
  logic take;

  assign take = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      idx   <= '0;
    end else if (!valid) begin
      if (start) begin
        valid <= 1'b1;
        idx   <= '0;
      end
    end else if (take) begin
      if (!enable)              valid <= 1'b0;
      else if (idx >= len_m1)   idx   <= '0;
      else                      idx   <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/pat_replay_gen.sv
module pat_replay_gen
  import prg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = LEN_LSB + AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pat_we,
  input  logic [AW-1:0]     pat_addr,
  input  logic [DATA_W-1:0] pat_wdata,
  input  logic              csr_we,
  input  logic              csr_sel,
  input  logic [CW-1:0]     csr_wdata,
  output logic [CW-1:0]     csr_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic          enable;
  logic          start;
  logic [AW-1:0] len_m1;
  logic [AW-1:0] rd_idx;
  logic          buf_we;

  assign buf_we = pat_we && !enable && !out_valid;

  pat_csr #(.AW(AW)) u_csr (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .sel(csr_sel), .wdata(csr_wdata),
    .busy(out_valid), .rdata(csr_rdata), .enable(enable), .len_m1(len_m1),
    .start(start)
  );

  pat_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .len_m1(len_m1),
    .ready(out_ready), .valid(out_valid), .idx(rd_idx)
  );

  pat_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .wr_en(buf_we), .wr_addr(pat_addr), .wr_data(pat_wdata),
    .rd_addr(rd_idx), .rd_data(out_data)
  );
endmodule

// File: rtl/prg_checker.sv
module prg_checker #(
  parameter int DATA_W = 32,
  parameter int AW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              enable,
  input logic [AW-1:0]     len_m1,
  input logic [AW-1:0]     rd_idx
);
  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(rd_idx));

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && enable && rd_idx >= len_m1 |=> rd_idx == '0);

  a_r4_step_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && enable && rd_idx < len_m1 |=> rd_idx == $past(rd_idx) + 1'b1);

  a_r7_stop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !enable |=> !out_valid);

  a_r8_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> rd_idx == '0);
endmodule

bind pat_replay_gen prg_checker #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .enable(enable), .len_m1(len_m1), .rd_idx(rd_idx)
);

// File: tb/tb_pat_replay_gen.sv
module tb_pat_replay_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int CW = AW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pat_we = 1'b0;
  logic [AW-1:0] pat_addr = '0;
  logic [DW-1:0] pat_wdata = '0;
  logic          csr_we = 1'b0;
  logic          csr_sel = 1'b0;
  logic [CW-1:0] csr_wdata = '0;
  logic [CW-1:0] csr_rdata;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pat_replay_gen dut (
    .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_addr(pat_addr),
    .pat_wdata(pat_wdata), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] pat_val(int i);
    logic [DW-1:0] v;
    v = DW'(i) * 32'h0100_0193;
    return v ^ 32'hC3A5_0000;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_wr(logic sel, logic [CW-1:0] d);
    csr_sel = sel; csr_wdata = d; csr_we = 1'b1;
    @(posedge clk); @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(logic sel, output logic [CW-1:0] d);
    csr_sel = sel; #1;
    d = csr_rdata;
  endtask

  task automatic pat_wr(int a, logic [DW-1:0] d);
    pat_addr = AW'(a); pat_wdata = d; pat_we = 1'b1;
    @(posedge clk); @(negedge clk);
    pat_we = 1'b0;
  endtask

  task automatic run_len(int len, int n_xfer);
    logic [CW-1:0] rd;
    int exp_i = 0;
    int xfers = 0;
    int cyc = 0;
    bit prev_r = 1'b1;
    bit r;
    string tag;
    out_ready = 1'b0;
    csr_wr(1'b0, CW'(((len - 1) << 1) | 1));
    csr_rd(1'b0, rd);
    chk("R6", DW'(rd), DW'(((len - 1) << 1) | 1));
    csr_rd(1'b1, rd);
    chk("R6", DW'(rd), 1);
    pat_wr(0, 32'hDEAD_0000 | DW'(len));
    chk("R8", DW'(out_valid), 1);
    chk("R9", out_data, pat_val(0));
    while (xfers < n_xfer) begin
      if (!prev_r)                               tag = "R5";
      else if (exp_i == 0)                       tag = "R3";
      else if (exp_i == 1)                       tag = "R2";
      else if (len == 1 || len == 2 || len == 256) tag = "R10";
      else                                       tag = "R4";
      chk(tag, {out_valid, out_data[DW-2:0]}, {1'b1, pat_val(exp_i)[DW-2:0]});
      chk(tag, out_data, pat_val(exp_i));
      r = ((cyc * 5 + len) % 7) != 3;
      cyc++;
      out_ready = r;
      prev_r = r;
      if (r) begin
        xfers++;
        exp_i = (exp_i == len - 1) ? 0 : exp_i + 1;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    csr_wr(1'b0, CW'((len - 1) << 1));
    chk("R7", DW'(out_valid), 1);
    chk("R7", out_data, pat_val(exp_i));
    out_ready = 1'b1;
    @(negedge clk);
    chk("R7", DW'(out_valid), 0);
    csr_rd(1'b1, rd);
    chk("R6", DW'(rd), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    logic [CW-1:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", DW'(out_valid), 0);
    csr_rd(1'b0, rd);
    chk("R1", DW'(rd), 0);
    csr_rd(1'b1, rd);
    chk("R1", DW'(rd), 0);
    for (int i = 0; i < 256; i++) pat_wr(i, pat_val(i));
    run_len(1, 5);
    run_len(2, 7);
    run_len(3, 9);
    run_len(32, 67);
    run_len(256, 515);
    run_len(2, 6);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule